// File: doc/BRIEF.md
# Switch Reset Exit and Strap Boot Sequencer

This block decides when the core of a multi-port switch leaves reset. An active-low fundamental reset input is passed through a flop synchronizer, so the reset takes hold at once but ends on a clock edge. Once the synchronized reset has been released, the block waits a fixed settle window and then latches the configuration straps in a single capture. The straps are the boot mode, the halt request, the port-merge select and the management-bus speed select. From then on, changes on those pins have no effect.

After the capture, the sequencer takes one of three paths:
- A halt request parks the core in reset while the management bus stays enabled. Software ends the halt by clearing a control bit through a small register-write port.
- EEPROM boot mode raises a load request and waits for a done handshake before it releases the core.
- A reserved boot-mode code traps the block in a fault state. That state lasts until the next fundamental reset.

The lane-merge and bus-speed straps are decoded onto plain outputs for the port and bus logic.

States:
- ST_SAMPLE counts the settle window. It then captures the straps and goes to ST_DECODE.
- ST_DECODE branches on the latched straps:
  - a reserved mode goes to ST_FAULT;
  - otherwise a halt request goes to ST_HALT;
  - otherwise EEPROM mode goes to ST_EELOAD;
  - otherwise the sequencer goes to ST_RUN.
- ST_HALT leaves when the halt bit is zero. It goes to ST_EELOAD in EEPROM mode and to ST_RUN otherwise.
- ST_EELOAD goes to ST_RUN on ee_done.
- ST_RUN and ST_FAULT are terminal until the next fundamental reset.

Top module: `rst_boot_seq`

## Requirements
- R1: While fund_rst_n is low, all outputs are at their reset values without waiting for a clock edge. Those values are core_rst_n=0, mgmt_bus_en=0, ee_load_req=0, mode_err=0, merge_x8=0, smb_slow=0 and p0_width=4. The end of reset passes through a two-flop synchronizer.
- R2: The straps are captured once, SETTLE_CYCLES clocks after the synchronized release. Strap pin changes made after the capture do not alter merge_x8, p0_width or smb_slow.
- R3: If strap_halt is 1 at capture, the core stays in reset (core_rst_n=0) and mgmt_bus_en=1 for as long as the halt bit is set.
- R4: The halt bit sits at bit 0 of the control register, at address CTL_ADDR (default 2). A write is accepted only when all of the following hold:
  - mgmt_bus_en is 1;
  - the address matches;
  - data bits 7..1 are all zero.

  An accepted write with bit 0 = 0 ends the halt, and the core is released two clocks after the write edge. Any other write is ignored.
- R5: Boot-mode code 0 releases the core with ee_load_req held at 0. Code 1 raises ee_load_req and holds the core in reset until ee_done is sampled high. The core is released on that edge, and ee_load_req falls at the same edge.
- R6: Boot-mode codes 2 to 7 set mode_err. The core then stays in reset with ee_load_req=0, and clearing the halt bit does not release it. mode_err clears only on a new fundamental reset.
- R7: strap_merge_n = 0 gives merge_x8=1 and p0_width=8. strap_merge_n = 1 gives merge_x8=0 and p0_width=4.
- R8: smb_slow follows the latched slow strap (1 = 100 kHz). No register write changes it.
- R9: With both a halt request and EEPROM mode, the EEPROM phase starts only after the halt is cleared. While halted, ee_load_req=0 and ee_done is ignored.
- R10: Once the core has been released, writing the halt bit to 1 does not put the core back into reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| fund_rst_n | input | 1 | Asynchronous fundamental reset, active low |
| strap_halt | input | 1 | Halt-in-reset strap |
| strap_mode | input | MODE_W (3) | Boot-mode strap (0 plain, 1 EEPROM, others reserved) |
| strap_merge_n | input | 1 | Port 0/1 merge strap, active low |
| strap_slow | input | 1 | Management-bus master slow-speed strap |
| ee_done | input | 1 | EEPROM initialization finished |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W (4) | Register write address |
| reg_wr_data | input | DATA_W (8) | Register write data |
| core_rst_n | output | 1 | Core reset, active low |
| mgmt_bus_en | output | 1 | Master and slave management bus enable |
| ee_load_req | output | 1 | EEPROM load request |
| mode_err | output | 1 | Sticky reserved-mode error |
| merge_x8 | output | 1 | Ports 0 and 1 form one x8 port |
| p0_width | output | WID_W (4) | Lane count of port 0 |
| smb_slow | output | 1 | Management-bus master runs at 100 kHz |

## Verification
The sequencer is exercised with these strap patterns:
- plain boot;
- plain boot with merge and slow straps;
- halt only;
- EEPROM only;
- halt combined with EEPROM;
- a reserved mode code.

Each pattern steers the state machine down a different branch out of ST_DECODE. The halt pattern tells accepted control writes apart from writes with a wrong address or with reserved bits set. The combined pattern shows that the EEPROM phase is ordered after the halt. Reapplying reset with changed straps, and toggling pins after capture, separates a true one-time latch from a pass-through of the pins.

// File: rtl/rst_boot_pkg.sv
package rst_boot_pkg;

    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_DECODE,
        ST_HALT,
        ST_EELOAD,
        ST_RUN,
        ST_FAULT
    } seq_state_e;

    typedef enum logic [1:0] {
        BOOT_PLAIN,
        BOOT_EEPROM,
        BOOT_BAD
    } boot_kind_e;

    typedef struct packed {
        logic       halt;
        boot_kind_e kind;
        logic       merge;
        logic       slow;
    } strap_cfg_t;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign srst_n = chain_q[STAGES-1];

    // R1
    sync_rise_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(srst_n) |-> $past(arst_n));

endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import rst_boot_pkg::*;
#(
    parameter int unsigned MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              strap_halt,
    input  logic [MODE_W-1:0] strap_mode,
    input  logic              strap_merge_n,
    input  logic              strap_slow,
    output strap_cfg_t        cfg,
    output logic              cfg_valid
);

    localparam logic [MODE_W-1:0] CODE_PLAIN  = MODE_W'(0);
    localparam logic [MODE_W-1:0] CODE_EEPROM = MODE_W'(1);

    strap_cfg_t cfg_q;
    logic       valid_q;
    boot_kind_e kind_dec;

    always_comb begin
        if (strap_mode == CODE_PLAIN) begin
            kind_dec = BOOT_PLAIN;
        end else if (strap_mode == CODE_EEPROM) begin
            kind_dec = BOOT_EEPROM;
        end else begin
            kind_dec = BOOT_BAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '{halt: 1'b0, kind: BOOT_PLAIN, merge: 1'b0, slow: 1'b0};
            valid_q <= 1'b0;
        end else if (capture && !valid_q) begin
            cfg_q.halt  <= strap_halt;
            cfg_q.kind  <= kind_dec;
            cfg_q.merge <= ~strap_merge_n;
            cfg_q.slow  <= strap_slow;
            valid_q     <= 1'b1;
        end
    end

    assign cfg       = cfg_q;
    assign cfg_valid = valid_q;

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> $stable(cfg_q));

endmodule

// File: rtl/rst_boot_fsm.sv
module rst_boot_fsm
    import rst_boot_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 8,
    parameter int unsigned ADDR_W        = 4,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CTL_ADDR      = 2,
    parameter int unsigned HALT_POS      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strap_cfg_t        cfg,
    input  logic              cfg_valid,
    input  logic              ee_done,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic              capture,
    output logic              core_rst_n,
    output logic              mgmt_bus_en,
    output logic              ee_load_req,
    output logic              mode_err
);

    localparam int unsigned       CNT_W       = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0]  SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [DATA_W-1:0] HALT_MASK   = DATA_W'(1) << HALT_POS;

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             halt_bit;
    logic             wr_ok;

    assign capture = (state_q == ST_SAMPLE) && (cnt_q == SETTLE_LAST);
    assign wr_ok   = reg_wr_en && mgmt_bus_en
                  && (reg_wr_addr == ADDR_W'(CTL_ADDR))
                  && ((reg_wr_data & ~HALT_MASK) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SAMPLE;
            cnt_q    <= '0;
            halt_bit <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SAMPLE && !capture) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_DECODE) begin
                halt_bit <= cfg.halt;
            end else if (wr_ok) begin
                halt_bit <= reg_wr_data[HALT_POS];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: begin
                if (capture) state_d = ST_DECODE;
            end
            ST_DECODE: begin
                if (cfg_valid) begin
                    if (cfg.kind == BOOT_BAD)         state_d = ST_FAULT;
                    else if (cfg.halt)                state_d = ST_HALT;
                    else if (cfg.kind == BOOT_EEPROM) state_d = ST_EELOAD;
                    else                              state_d = ST_RUN;
                end
            end
            ST_HALT: begin
                if (!halt_bit) begin
                    state_d = (cfg.kind == BOOT_EEPROM) ? ST_EELOAD : ST_RUN;
                end
            end
            ST_EELOAD: begin
                if (ee_done) state_d = ST_RUN;
            end
            ST_RUN:   state_d = ST_RUN;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_FAULT;
        endcase
    end

    always_comb begin
        core_rst_n  = 1'b0;
        mgmt_bus_en = 1'b0;
        ee_load_req = 1'b0;
        mode_err    = 1'b0;
        unique case (state_q)
            ST_SAMPLE, ST_DECODE: ;
            ST_HALT:   mgmt_bus_en = 1'b1;
            ST_EELOAD: begin
                mgmt_bus_en = 1'b1;
                ee_load_req = 1'b1;
            end
            ST_RUN: begin
                mgmt_bus_en = 1'b1;
                core_rst_n  = 1'b1;
            end
            ST_FAULT: begin
                mgmt_bus_en = 1'b1;
                mode_err    = 1'b1;
            end
            default: ;
        endcase
    end

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && halt_bit) |=> !core_rst_n);

    // R4
    halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(halt_bit) |-> $past(wr_ok || state_q == ST_DECODE));

    // R5
    ee_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_rst_n) && cfg.kind == BOOT_EEPROM) |-> $past(ee_done));

    // R6
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> (mode_err && !core_rst_n));

    // R10
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n |=> core_rst_n);

endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq
    import rst_boot_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned SETTLE_CYCLES  = 8,
    parameter int unsigned MODE_W         = 3,
    parameter int unsigned ADDR_W         = 4,
    parameter int unsigned DATA_W         = 8,
    parameter int unsigned CTL_ADDR       = 2,
    parameter int unsigned HALT_POS       = 0,
    parameter int unsigned LANES_PER_PORT = 4,
    localparam int unsigned WID_W         = $clog2(2 * LANES_PER_PORT + 1)
) (
    input  logic              clk,
    input  logic              fund_rst_n,
    input  logic              strap_halt,
    input  logic [MODE_W-1:0] strap_mode,
    input  logic              strap_merge_n,
    input  logic              strap_slow,
    input  logic              ee_done,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic              core_rst_n,
    output logic              mgmt_bus_en,
    output logic              ee_load_req,
    output logic              mode_err,
    output logic              merge_x8,
    output logic [WID_W-1:0]  p0_width,
    output logic              smb_slow
);

    logic       rst_s_n;
    logic       capture;
    strap_cfg_t cfg;
    logic       cfg_valid;

    rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (fund_rst_n),
        .srst_n (rst_s_n)
    );

    strap_latch #(.MODE_W(MODE_W)) u_latch (
        .clk           (clk),
        .rst_n         (rst_s_n),
        .capture       (capture),
        .strap_halt    (strap_halt),
        .strap_mode    (strap_mode),
        .strap_merge_n (strap_merge_n),
        .strap_slow    (strap_slow),
        .cfg           (cfg),
        .cfg_valid     (cfg_valid)
    );

    rst_boot_fsm #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .CTL_ADDR      (CTL_ADDR),
        .HALT_POS      (HALT_POS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_s_n),
        .cfg         (cfg),
        .cfg_valid   (cfg_valid),
        .ee_done     (ee_done),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .capture     (capture),
        .core_rst_n  (core_rst_n),
        .mgmt_bus_en (mgmt_bus_en),
        .ee_load_req (ee_load_req),
        .mode_err    (mode_err)
    );

    assign merge_x8 = cfg.merge;
    assign smb_slow = cfg.slow;
    assign p0_width = cfg.merge ? WID_W'(2 * LANES_PER_PORT) : WID_W'(LANES_PER_PORT);

    // R7
    width_match_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
        merge_x8 |-> (p0_width == WID_W'(2 * LANES_PER_PORT)));

    // R1
    run_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
        core_rst_n |-> mgmt_bus_en);

endmodule

// File: tb/sim_rst_boot_seq.sv
module sim_rst_boot_seq;

    logic       clk = 1'b0;
    logic       fund_rst_n = 1'b0;
    logic       strap_halt = 1'b0;
    logic [2:0] strap_mode = 3'd0;
    logic       strap_merge_n = 1'b1;
    logic       strap_slow = 1'b0;
    logic       ee_done = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [3:0] reg_wr_addr = 4'd0;
    logic [7:0] reg_wr_data = 8'd0;
    logic       core_rst_n, mgmt_bus_en, ee_load_req, mode_err, merge_x8, smb_slow;
    logic [3:0] p0_width;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    rst_boot_seq u0 (
        .clk(clk), .fund_rst_n(fund_rst_n), .strap_halt(strap_halt),
        .strap_mode(strap_mode), .strap_merge_n(strap_merge_n),
        .strap_slow(strap_slow), .ee_done(ee_done), .reg_wr_en(reg_wr_en),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .core_rst_n(core_rst_n), .mgmt_bus_en(mgmt_bus_en),
        .ee_load_req(ee_load_req), .mode_err(mode_err), .merge_x8(merge_x8),
        .p0_width(p0_width), .smb_slow(smb_slow)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic boot(input logic halt, input logic [2:0] mode, input logic mrg_n, input logic slow);
        @(negedge clk);
        fund_rst_n = 1'b0;
        #1;
        chk("R1", "core_rst_n async", int'(core_rst_n), 0);
        strap_halt = halt; strap_mode = mode; strap_merge_n = mrg_n; strap_slow = slow;
        ee_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "mgmt_bus_en in reset", int'(mgmt_bus_en), 0);
        chk("R1", "mode_err/ee_load/merge/slow in reset",
            int'({mode_err, ee_load_req, merge_x8, smb_slow}), 0);
        chk("R1", "p0_width in reset", int'(p0_width), 4);
        fund_rst_n = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic t_plain;
        boot(1'b0, 3'd0, 1'b1, 1'b0);
        chk("R5", "plain core released", int'(core_rst_n), 1);
        chk("R5", "plain no ee_load_req", int'(ee_load_req), 0);
        chk("R7", "unmerged merge_x8", int'(merge_x8), 0);
        chk("R7", "unmerged width", int'(p0_width), 4);
        chk("R8", "fast bus", int'(smb_slow), 0);
        strap_merge_n = 1'b0; strap_slow = 1'b1; strap_mode = 3'd6;
        repeat (5) @(negedge clk);
        chk("R2", "merge after late strap change", int'(merge_x8), 0);
        chk("R2", "slow after late strap change", int'(smb_slow), 0);
        chk("R2", "no error after late mode change", int'(mode_err), 0);
        reg_write(4'd2, 8'h01);
        repeat (5) @(negedge clk);
        chk("R10", "core stays out of reset", int'(core_rst_n), 1);
    endtask

    task automatic t_merge_slow;
        boot(1'b0, 3'd0, 1'b0, 1'b1);
        chk("R7", "merged merge_x8", int'(merge_x8), 1);
        chk("R7", "merged width", int'(p0_width), 8);
        chk("R8", "slow bus", int'(smb_slow), 1);
        reg_write(4'd2, 8'h00);
        reg_write(4'd2, 8'hFE);
        repeat (3) @(negedge clk);
        chk("R8", "slow after writes", int'(smb_slow), 1);
    endtask

    task automatic t_halt;
        boot(1'b1, 3'd0, 1'b1, 1'b0);
        chk("R3", "halted core", int'(core_rst_n), 0);
        chk("R3", "halted bus enabled", int'(mgmt_bus_en), 1);
        reg_write(4'd3, 8'h00);
        repeat (6) @(negedge clk);
        chk("R4", "wrong address ignored", int'(core_rst_n), 0);
        reg_write(4'd2, 8'h10);
        repeat (6) @(negedge clk);
        chk("R4", "reserved bits set ignored", int'(core_rst_n), 0);
        reg_write(4'd2, 8'h00);
        chk("R4", "one cycle after write", int'(core_rst_n), 0);
        @(negedge clk);
        chk("R4", "released two cycles after write", int'(core_rst_n), 1);
    endtask

    task automatic t_ee;
        boot(1'b0, 3'd1, 1'b1, 1'b0);
        chk("R5", "ee_load_req raised", int'(ee_load_req), 1);
        repeat (20) @(negedge clk);
        chk("R5", "core held while loading", int'(core_rst_n), 0);
        ee_done = 1'b1;
        @(negedge clk);
        chk("R5", "core released on done", int'(core_rst_n), 1);
        chk("R5", "ee_load_req dropped", int'(ee_load_req), 0);
        ee_done = 1'b0;
    endtask

    task automatic t_halt_ee;
        boot(1'b1, 3'd1, 1'b1, 1'b0);
        ee_done = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9", "no ee_load_req while halted", int'(ee_load_req), 0);
        chk("R9", "ee_done ignored while halted", int'(core_rst_n), 0);
        ee_done = 1'b0;
        reg_write(4'd2, 8'h00);
        repeat (3) @(negedge clk);
        chk("R9", "ee_load_req after halt cleared", int'(ee_load_req), 1);
        chk("R9", "core held until done", int'(core_rst_n), 0);
        ee_done = 1'b1;
        @(negedge clk);
        chk("R9", "core released after load", int'(core_rst_n), 1);
        ee_done = 1'b0;
    endtask

    task automatic t_reserved;
        boot(1'b1, 3'd5, 1'b1, 1'b0);
        chk("R6", "mode_err set", int'(mode_err), 1);
        chk("R6", "core held", int'(core_rst_n), 0);
        chk("R6", "no ee_load_req", int'(ee_load_req), 0);
        reg_write(4'd2, 8'h00);
        ee_done = 1'b1;
        repeat (6) @(negedge clk);
        chk("R6", "halt clear does not release", int'(core_rst_n), 0);
        chk("R6", "mode_err sticky", int'(mode_err), 1);
        ee_done = 1'b0;
        boot(1'b0, 3'd0, 1'b1, 1'b0);
        chk("R6", "mode_err cleared by reset", int'(mode_err), 0);
        chk("R6", "core released after good reset", int'(core_rst_n), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        t_plain();
        t_merge_slow();
        t_halt();
        t_ee();
        t_halt_ee();
        t_reserved();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule